// File: doc/BRIEF.md
# Static Branch Prediction Fetch Control

This block produces the fetch address for the front end of a five-stage in-order pipeline. While an instruction is being fetched, a predecode step reports whether it is a conditional branch, gives its signed byte displacement and gives its hint bit. The block predicts the branch direction with a static rule picked by a configuration input. It keeps no history of past outcomes. A predicted-taken branch sends the next fetch straight to `fetch_pc + displacement`. A predicted-not-taken branch lets fetch carry on down the sequential path without a stall.

The decode stage resolves each branch one cycle after it is fetched and reports the actual direction and target. When the prediction was wrong, the block raises `squash` in that same cycle. The consumer must turn the instruction being fetched in that cycle into a no-op, so it writes no register. Fetch then moves to the correct address on the next edge, which costs one cycle. A saturating counter records every wrong prediction.

There are three rules. The first always predicts not taken. The second predicts taken only for a backward (negative) displacement. The third is the second rule with the answer inverted whenever the instruction's hint bit is set.

Top module: `static_bp_fetch`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets `fetch_pc` to `RESET_PC`, `mispredict_cnt` to zero and `squash` to 0.
- R2: With policy code 2'b00 or 2'b11 (not-taken), a fetched branch is followed by a fetch at `fetch_pc + 4`, whatever its displacement or hint.
- R3: With policy code 2'b01 (sign rule), a fetched branch whose displacement is negative sends the next fetch to `fetch_pc + sign_extend(f_disp)`. A zero or positive displacement gives `fetch_pc + 4`. The hint bit has no effect under this rule.
- R4: With policy code 2'b10 (hinted sign rule), a set hint inverts the R3 prediction: a negative displacement gives `fetch_pc + 4` and a zero or positive one gives the target.
- R5: If a branch predicted not-taken resolves taken (`res_valid` and `res_taken` in the cycle after its fetch), `squash` is 1 in that cycle and the next `fetch_pc` is `res_target`.
- R6: If a branch predicted taken resolves not-taken, `squash` is 1 in that cycle and the next `fetch_pc` is the branch address + 4.
- R7: A correctly predicted branch raises no `squash`, and fetch goes on from the address it was already following.
- R8: `mispredict_cnt` goes up by one on every cycle with `squash` and holds at all ones once it reaches that value.
- R9: `res_valid` has no effect when no branch was fetched in the previous cycle. A branch flag on the instruction fetched during a `squash` cycle is ignored, so it makes no prediction and has no resolution.
- R10: `policy_sel` is taken in only in cycles with no branch in flight. In a cycle where the previous fetch was a branch, the rule held from the earlier cycle is used.
- R11: A fetched non-branch instruction with no misprediction pending is followed by a fetch at `fetch_pc + 4`, and `next_pc` always shows the value `fetch_pc` takes at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| policy_sel | input | 2 | Prediction rule: 00/11 not-taken, 01 sign, 10 hinted sign |
| f_branch | input | 1 | Instruction at `fetch_pc` is a conditional branch |
| f_disp | input | DW | Signed byte displacement of that branch |
| f_hint | input | 1 | Hint bit of that branch |
| res_valid | input | 1 | Decode resolves the branch fetched in the previous cycle |
| res_taken | input | 1 | Actual direction of the resolved branch |
| res_target | input | AW | Actual target of the resolved branch |
| fetch_pc | output | AW | Address fetched in this cycle |
| next_pc | output | AW | Address to fetch in the next cycle |
| squash | output | 1 | Instruction fetched in this cycle must become a no-op |
| mispredict_cnt | output | CNT_W | Saturating count of wrong predictions |

## Verification
The assertions take one thing for granted: a branch is resolved exactly one cycle after it is fetched, or not at all. An in-flight branch with no resolution in that cycle counts as correctly predicted. The redirect checks compare `fetch_pc` with the target presented at resolution, so the inputs are trusted to be stable for the whole cycle. The stimulus drives all inputs once per cycle, shortly after the rising edge. It gives each branch its resolution in the following cycle, and it sends stray `res_valid` pulses only on purpose, when no branch is in flight.

// File: rtl/static_bp_fetch.sv
module static_bp_fetch #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int CNT_W = 16,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       policy_sel,
  input  logic             f_branch,
  input  logic [DW-1:0]    f_disp,
  input  logic             f_hint,
  input  logic             res_valid,
  input  logic             res_taken,
  input  logic [AW-1:0]    res_target,
  output logic [AW-1:0]    fetch_pc,
  output logic [AW-1:0]    next_pc,
  output logic             squash,
  output logic [CNT_W-1:0] mispredict_cnt
);

  localparam logic [1:0] POL_SIGN = 2'b01;
  localparam logic [1:0] POL_HINT = 2'b10;
  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [1:0]    pol_q;
  logic          inflight_q;
  logic          pred_q;
  logic [AW-1:0] bpc_q;

  logic [1:0]    pol_eff;
  logic          backward;
  logic          guess;
  logic          pred_taken;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] tgt_pc;

  assign pol_eff  = inflight_q ? pol_q : policy_sel;
  assign backward = f_disp[DW-1];
  assign seq_pc   = fetch_pc + STEP;
  assign tgt_pc   = fetch_pc + {{(AW-DW){f_disp[DW-1]}}, f_disp};

  always_comb begin
    case (pol_eff)
      POL_SIGN: guess = backward;
      POL_HINT: guess = backward ^ f_hint;
      default:  guess = 1'b0;
    endcase
  end

  assign squash     = res_valid && inflight_q && (res_taken != pred_q);
  assign pred_taken = f_branch && !squash && guess;

  always_comb begin
    if (squash)
      next_pc = res_taken ? res_target : bpc_q + STEP;
    else if (pred_taken)
      next_pc = tgt_pc;
    else
      next_pc = seq_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc       <= RESET_PC;
      pol_q          <= '0;
      inflight_q     <= 1'b0;
      pred_q         <= 1'b0;
      bpc_q          <= '0;
      mispredict_cnt <= '0;
    end else begin
      fetch_pc   <= next_pc;
      pol_q      <= pol_eff;
      inflight_q <= f_branch && !squash;
      pred_q     <= pred_taken;
      bpc_q      <= fetch_pc;
      if (squash && mispredict_cnt != CNT_MAX)
        mispredict_cnt <= mispredict_cnt + 1'b1;
    end
  end

  // R5
  redirect_taken_chk: assert property (@(posedge clk) disable iff (rst)
    squash && res_taken |=> fetch_pc == $past(res_target));

  // R6
  redirect_fall_chk: assert property (@(posedge clk) disable iff (rst)
    squash && !res_taken |=> fetch_pc == $past(fetch_pc, 2) + STEP);

  // R9
  single_squash_chk: assert property (@(posedge clk) disable iff (rst)
    squash |=> !squash);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    squash && mispredict_cnt != CNT_MAX |=> mispredict_cnt == $past(mispredict_cnt) + 1'b1);

  // R8
  cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
    !squash |=> mispredict_cnt == $past(mispredict_cnt));

  // R2
  seq_policy_chk: assert property (@(posedge clk) disable iff (rst)
    !squash && pol_eff != POL_SIGN && pol_eff != POL_HINT |=> fetch_pc == $past(fetch_pc) + STEP);

  // R11
  next_pc_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> fetch_pc == $past(next_pc));

endmodule

// File: tb/test_static_bp_fetch.sv
module test_static_bp_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam logic [AW-1:0] RPC = 32'h0000_0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] policy_sel = 2'b00;
  logic f_branch = 1'b0;
  logic [DW-1:0] f_disp = '0;
  logic f_hint = 1'b0;
  logic res_valid = 1'b0;
  logic res_taken = 1'b0;
  logic [AW-1:0] res_target = '0;
  logic [AW-1:0] fetch_pc, next_pc;
  logic squash;
  logic [CW-1:0] mispredict_cnt;

  static_bp_fetch #(.AW(AW), .DW(DW), .CNT_W(CW), .RESET_PC(RPC)) i_static_bp_fetch (
    .clk(clk), .rst(rst), .policy_sel(policy_sel), .f_branch(f_branch), .f_disp(f_disp),
    .f_hint(f_hint), .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
    .fetch_pc(fetch_pc), .next_pc(next_pc), .squash(squash), .mispredict_cnt(mispredict_cnt));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [AW-1:0] pc;
    logic [AW-1:0] nxt;
    logic          sq;
    logic [CW-1:0] cnt;
    string         tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;

  logic [AW-1:0] m_pc = RPC;
  logic [AW-1:0] m_bpc = '0;
  logic [CW-1:0] m_cnt = '0;
  logic [1:0]    m_pol = 2'b00;
  logic          m_infl = 1'b0;
  logic          m_pred = 1'b0;

  task automatic step(input logic br, input logic [DW-1:0] d, input logic h, input logic [1:0] pol,
                      input logic rv, input logic rt, input logic [AW-1:0] rtgt, input string tag);
    logic [1:0] eff;
    logic g, sq, pr;
    logic [AW-1:0] nx;
    exp_t e;
    policy_sel = pol; f_branch = br; f_disp = d; f_hint = h;
    res_valid = rv; res_taken = rt; res_target = rtgt;
    eff = m_infl ? m_pol : pol;
    g = (eff == 2'b01) ? d[DW-1] : (eff == 2'b10) ? (d[DW-1] ^ h) : 1'b0;
    sq = rv && m_infl && (rt != m_pred);
    pr = br && !sq && g;
    nx = sq ? (rt ? rtgt : m_bpc + 4) : pr ? m_pc + {{(AW-DW){d[DW-1]}}, d} : m_pc + 4;
    e.pc = m_pc; e.nxt = nx; e.sq = sq; e.cnt = m_cnt; e.tag = tag;
    q.push_back(e);
    m_pol = eff;
    if (sq && m_cnt != {CW{1'b1}}) m_cnt = m_cnt + 1'b1;
    m_infl = br && !sq;
    m_pred = pr;
    m_bpc = m_pc;
    m_pc = nx;
    @(posedge clk); #1;
  endtask

  task automatic idle(input logic [1:0] pol, input string tag);
    step(1'b0, '0, 1'b0, pol, 1'b0, 1'b0, '0, tag);
  endtask

  always @(negedge clk) begin
    if (q.size() != 0) begin
      exp_t e;
      logic bad;
      e = q.pop_front();
      bad = 1'b0;
      checks++;
      if (fetch_pc !== e.pc) begin bad = 1'b1; $display("FAIL %s: fetch_pc=%h expected %h", e.tag, fetch_pc, e.pc); end
      if (next_pc !== e.nxt) begin bad = 1'b1; $display("FAIL %s: next_pc=%h expected %h", e.tag, next_pc, e.nxt); end
      if (squash !== e.sq) begin bad = 1'b1; $display("FAIL %s: squash=%b expected %b", e.tag, squash, e.sq); end
      if (mispredict_cnt !== e.cnt) begin bad = 1'b1; $display("FAIL %s: mispredict_cnt=%0d expected %0d", e.tag, mispredict_cnt, e.cnt); end
      if (bad) fails++;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (fetch_pc !== RPC || squash !== 1'b0 || mispredict_cnt !== '0) begin
      fails++;
      $display("FAIL R1: pc=%h sq=%b cnt=%0d expected %h 0 0", fetch_pc, squash, mispredict_cnt, RPC);
    end
    @(posedge clk); #1;
    rst = 1'b0;

    // R11 / R2: sequential flow and not-taken rule
    idle(2'b00, "R11");
    step(1'b1, 16'hFFF0, 1'b1, 2'b00, 1'b0, 1'b0, '0, "R2");
    step(1'b0, '0, 1'b0, 2'b00, 1'b1, 1'b0, '0, "R7");
    step(1'b1, 16'h0040, 1'b0, 2'b11, 1'b0, 1'b0, '0, "R2");
    step(1'b0, '0, 1'b0, 2'b11, 1'b1, 1'b0, '0, "R7");
    // R5: not-taken prediction wrong, squashed fetch carries a branch flag (R9)
    step(1'b1, 16'h0020, 1'b0, 2'b00, 1'b0, 1'b0, '0, "R5");
    step(1'b1, 16'hFF00, 1'b0, 2'b01, 1'b1, 1'b1, 32'h0000_2000, "R5");
    step(1'b0, '0, 1'b0, 2'b01, 1'b1, 1'b0, 32'h0000_3000, "R9");
    // R9: stray resolution with nothing in flight
    step(1'b0, '0, 1'b0, 2'b01, 1'b1, 1'b1, 32'h0000_4000, "R9");
    // R3: sign rule
    step(1'b1, 16'hFFE0, 1'b0, 2'b01, 1'b0, 1'b0, '0, "R3");
    step(1'b0, '0, 1'b0, 2'b01, 1'b1, 1'b1, 32'h0000_1FE0, "R7");
    step(1'b1, 16'hFFE0, 1'b1, 2'b01, 1'b0, 1'b0, '0, "R3");
    step(1'b0, '0, 1'b0, 2'b01, 1'b1, 1'b1, 32'h0000_1FC0, "R7");
    step(1'b1, 16'h0000, 1'b0, 2'b01, 1'b0, 1'b0, '0, "R3");
    step(1'b0, '0, 1'b0, 2'b01, 1'b1, 1'b0, '0, "R7");
    step(1'b1, 16'h0100, 1'b1, 2'b01, 1'b0, 1'b0, '0, "R3");
    step(1'b0, '0, 1'b0, 2'b01, 1'b1, 1'b0, '0, "R7");
    // R6: taken prediction wrong
    step(1'b1, 16'hFF80, 1'b0, 2'b01, 1'b0, 1'b0, '0, "R6");
    step(1'b0, '0, 1'b0, 2'b01, 1'b1, 1'b0, '0, "R6");
    idle(2'b01, "R11");
    // R4: hinted sign rule
    step(1'b1, 16'hFFF0, 1'b1, 2'b10, 1'b0, 1'b0, '0, "R4");
    step(1'b0, '0, 1'b0, 2'b10, 1'b1, 1'b0, '0, "R7");
    step(1'b1, 16'h0030, 1'b1, 2'b10, 1'b0, 1'b0, '0, "R4");
    step(1'b0, '0, 1'b0, 2'b10, 1'b1, 1'b1, 32'h0000_5000, "R7");
    step(1'b1, 16'hFFF0, 1'b0, 2'b10, 1'b0, 1'b0, '0, "R4");
    step(1'b0, '0, 1'b0, 2'b10, 1'b1, 1'b0, '0, "R6");
    // R10: policy change while a branch is in flight
    step(1'b1, 16'h0010, 1'b0, 2'b00, 1'b0, 1'b0, '0, "R10");
    step(1'b1, 16'hFFC0, 1'b0, 2'b01, 1'b1, 1'b0, '0, "R10");
    step(1'b0, '0, 1'b0, 2'b01, 1'b1, 1'b0, '0, "R10");
    step(1'b1, 16'hFFC0, 1'b0, 2'b01, 1'b0, 1'b0, '0, "R10");
    step(1'b0, '0, 1'b0, 2'b01, 1'b1, 1'b1, 32'h0000_6000, "R7");
    // R8: saturation of the counter
    for (int i = 0; i < 20; i++) begin
      step(1'b1, 16'h0008, 1'b0, 2'b00, 1'b0, 1'b0, '0, "R8");
      step(1'b0, '0, 1'b0, 2'b00, 1'b1, 1'b1, 32'h0000_7000 + 32'(i * 64), "R8");
    end
    idle(2'b00, "R8");
    idle(2'b00, "R11");
    @(posedge clk); #1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule